// File: doc/BRIEF.md
# SDRAM Command Stream Protocol Monitor

This block watches the command pins of a single-data-rate SDRAM interface without driving anything. On each rising clock edge it decodes the command from the chip select, row strobe, column strobe, write enable and clock enable, then updates a shadow model of four banks. Each bank in the model is either idle or open. It also keeps its own cycle timers for the spacing rules that an SDRAM part requires.

When a command breaks a bank-state rule or a spacing rule, the monitor sets a sticky flag for that rule and increments a saturating counter for that rule. It also records a code for the violation. The spacing limits are specified in nanoseconds. They become clock counts at elaboration from a clock-period parameter, rounded up. The monitor can sit next to a memory controller in a testbench or in silicon, and it reports only through its flag, code and counter outputs.

Top module: `sdram_proto_mon`

## Requirements
- R1: A cycle decodes as a command only when `cke` is high and `cs_n` is low. Any other cycle is a no-op and cannot raise a flag. The pin patterns on {`ras_n`,`cas_n`,`we_n`} are: 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 111 no-op.
- R2: A mode set or a refresh issued while any bank is open sets rule 0.
- R3: Any command other than a no-op issued 1 cycle after a mode set sets rule 1. The same command issued 2 cycles after is legal.
- R4: A read or write to an open bank fewer than ceil(20 ns / period) cycles after that bank's activate sets rule 2.
- R5: An activate to an idle bank fewer than ceil(65 ns / period) cycles after that bank's previous activate sets rule 3.
- R6: An activate to an idle bank fewer than ceil(20 ns / period) cycles after the bank closed sets rule 4. The bank can close by precharge or by the end of an auto-precharge burst.
- R7: An activate to a different bank than the previous activate, fewer than ceil(15 ns / period) cycles after it, sets rule 5.
- R8: A read or write with `addr_ap` high to an open bank starts an auto-precharge burst. The burst length comes from `addr_mode` at the last mode set: 0→1, 1→2, 2→4, other values→8, and the reset value is 1. Any read or write issued before the burst length has elapsed sets rule 6. The bank closes in the last cycle of the burst.
- R9: A read or write to an idle bank sets rule 7.
- R10: An activate to a bank that is already open sets rule 8.
- R11: A precharge with `addr_ap` high closes all four banks. With `addr_ap` low, it closes only the bank on `ba`.
- R12: `err_flags[r]` latches once rule r is violated. `err_code` holds the lowest rule number violated in the most recent violating cycle, or 15 if there has been none.
- R13: Rule r's counter occupies `err_count[8r+7:8r]` and saturates at 255. A high `clr` sampled on an edge zeroes all flags and counters and sets the code to 15.
- R14: After reset all flags and counters are 0, `err_code` is 15, every bank is idle and every timer is expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags, code and counters |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr_ap | input | 1 | Address bit 10: all-bank precharge or auto-precharge |
| addr_mode | input | 3 | Address bits 2..0: burst-length field on a mode set |
| err_flags | output | 9 | Sticky flag per rule |
| err_code | output | 4 | Lowest rule number of the latest violating cycle, 15 when none |
| err_count | output | 72 | Saturating 8-bit violation counter per rule |

## Verification
The bench drives directed command sequences. Each spacing rule is tried one cycle short of its limit and again exactly at its limit, so an off-by-one in any timer shows up as a flag that is missing or extra. The auto-precharge scenario issues an activate one cycle early and then at the exact cycle the bank becomes available, which separates the point where the burst ends from the point where the close takes effect. Commands are also hidden behind a high chip select or a low clock enable and then followed by a read. An idle-access flag on that read shows that the hidden command left no trace. The priority scenario violates two rules in the same cycle and confirms which code is reported.

// File: rtl/sdram_mon_pkg.sv
// Shared types and constants for the SDRAM protocol monitor.
// Assumes rule numbers are stable: they are visible on err_code and err_count.
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_MODE,
        CMD_REF,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_PRE
    } cmd_e;

    localparam int NRULE          = 9;
    localparam int CODE_W         = 4;
    localparam logic [CODE_W-1:0] CODE_NONE = '1;

    localparam int RULE_MODE_OPEN = 0;
    localparam int RULE_MODE_GAP  = 1;
    localparam int RULE_RCD       = 2;
    localparam int RULE_RC        = 3;
    localparam int RULE_RP        = 4;
    localparam int RULE_RRD       = 5;
    localparam int RULE_AP_BUSY   = 6;
    localparam int RULE_IDLE      = 7;
    localparam int RULE_DBL_ACT   = 8;

    // Converts a nanosecond limit to whole clocks, rounding up.
    function automatic int ns_to_clk(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Decodes the bus pins into one command per cycle.
// Assumes a low clock enable or a high chip select yields a no-op.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Pin pattern to command mapping.
    always_comb begin
        if (!cke || cs_n) begin
            cmd = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MODE;
                3'b001:  cmd = CMD_REF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_shadow.sv
// Shadow of one bank: open/idle state plus cycles since activate and close.
// Assumes do_close is asserted only while the bank is open.
module sdram_bank_shadow #(
    parameter int TMAX = 17,
    parameter int TW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_act,
    input  logic          do_close,
    output logic          is_open,
    output logic [TW-1:0] act_el,
    output logic [TW-1:0] pre_el
);

    localparam logic [TW-1:0] LIM = TW'(TMAX);

    // Open/idle state; an activate wins over a coincident close.
    always_ff @(posedge clk) begin
        if (!rst_n)        is_open <= 1'b0;
        else if (do_act)   is_open <= 1'b1;
        else if (do_close) is_open <= 1'b0;
    end

    // Elapsed cycles since the last activate, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          act_el <= LIM;
        else if (do_act)     act_el <= TW'(1);
        else if (act_el != LIM) act_el <= act_el + TW'(1);
    end

    // Elapsed cycles since the last close, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          pre_el <= LIM;
        else if (do_close)   pre_el <= TW'(1);
        else if (pre_el != LIM) pre_el <= pre_el + TW'(1);
    end

endmodule

// File: rtl/sdram_err_log.sv
// Sticky flags, saturating counters and the latest violation code.
// Assumes clear has priority over a coincident violation.
module sdram_err_log
    import sdram_mon_pkg::*;
#(
    parameter int NR    = 9,
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [NR-1:0]       hit,
    output logic [NR-1:0]       flags,
    output logic [CODE_W-1:0]   code,
    output logic [NR*CNT_W-1:0] counts
);

    logic [CODE_W-1:0] first_hit;

    // Lowest-numbered rule violated this cycle.
    always_comb begin
        first_hit = CODE_NONE;
        for (int i = NR - 1; i >= 0; i--) begin
            if (hit[i]) first_hit = CODE_W'(i);
        end
    end

    // Code of the latest violating cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) code <= CODE_NONE;
        else if (|hit)     code <= first_hit;
    end

    for (genvar r = 0; r < NR; r++) begin : g_rule
        logic [CNT_W-1:0] cnt;

        // Sticky flag for rule r.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) flags[r] <= 1'b0;
            else if (hit[r])   flags[r] <= 1'b1;
        end

        // Saturating violation count for rule r.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)              cnt <= '0;
            else if (hit[r] && (cnt != '1)) cnt <= cnt + CNT_W'(1);
        end

        assign counts[r*CNT_W +: CNT_W] = cnt;
    end

endmodule

// File: rtl/sdram_proto_mon.sv
// Passive SDRAM command-stream monitor: decodes commands, shadows bank
// state, times the spacing rules and logs violations per rule.
// Assumes a power-of-two bank count and that all pins are synchronous to clk.
module sdram_proto_mon
    import sdram_mon_pkg::*;
#(
    parameter int CLK_PS   = 4000,
    parameter int T_RCD_NS = 20,
    parameter int T_RC_NS  = 65,
    parameter int T_RP_NS  = 20,
    parameter int T_RRD_NS = 15,
    parameter int MODE_GAP = 2,
    parameter int NBANK    = 4,
    parameter int CNT_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [$clog2(NBANK)-1:0] ba,
    input  logic                   addr_ap,
    input  logic [2:0]             addr_mode,
    output logic [NRULE-1:0]       err_flags,
    output logic [CODE_W-1:0]      err_code,
    output logic [NRULE*CNT_W-1:0] err_count
);

    localparam int BAW   = $clog2(NBANK);
    localparam int TRCD  = ns_to_clk(T_RCD_NS, CLK_PS);
    localparam int TRC   = ns_to_clk(T_RC_NS, CLK_PS);
    localparam int TRP   = ns_to_clk(T_RP_NS, CLK_PS);
    localparam int TRRD  = ns_to_clk(T_RRD_NS, CLK_PS);
    localparam int TM1   = (TRC > TRCD) ? TRC : TRCD;
    localparam int TM2   = (TRP > TRRD) ? TRP : TRRD;
    localparam int TM3   = (TM1 > TM2) ? TM1 : TM2;
    localparam int TMAX  = (TM3 > MODE_GAP) ? TM3 : MODE_GAP;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int BLW   = 4;
    localparam logic [TW-1:0] LIM = TW'(TMAX);

    cmd_e              cmd;
    logic [NBANK-1:0]  bank_open;
    logic [NBANK-1:0]  bank_act;
    logic [NBANK-1:0]  bank_close;
    logic [TW-1:0]     act_el [NBANK];
    logic [TW-1:0]     pre_el [NBANK];
    logic [TW-1:0]     mode_el;
    logic [TW-1:0]     rrd_el;
    logic [BAW-1:0]    last_act_ba;
    logic [BLW-1:0]    burst_len;
    logic [BLW-1:0]    ap_left;
    logic [BAW-1:0]    ap_ba;
    logic              is_rw;
    logic              sel_open;
    logic              ap_run;
    logic              ap_start;
    logic [NRULE-1:0]  hit;

    sdram_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign sel_open = bank_open[ba];
    assign ap_run   = (ap_left != '0);
    assign ap_start = is_rw && addr_ap && sel_open && !ap_run;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Activate and close strobes for bank b.
        always_comb begin
            bank_act[b]   = (cmd == CMD_ACT) && (ba == BAW'(b));
            bank_close[b] = bank_open[b] &&
                ((cmd == CMD_PRE && (addr_ap || ba == BAW'(b))) ||
                 (ap_left == BLW'(1) && ap_ba == BAW'(b)) ||
                 (ap_start && burst_len == BLW'(1) && ba == BAW'(b)));
        end

        sdram_bank_shadow #(.TMAX(TMAX), .TW(TW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .do_act   (bank_act[b]),
            .do_close (bank_close[b]),
            .is_open  (bank_open[b]),
            .act_el   (act_el[b]),
            .pre_el   (pre_el[b])
        );
    end

    // Cycles since the last mode set, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               mode_el <= LIM;
        else if (cmd == CMD_MODE) mode_el <= TW'(1);
        else if (mode_el != LIM)  mode_el <= mode_el + TW'(1);
    end

    // Cycles since the last activate to any bank, and which bank it was.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_el      <= LIM;
            last_act_ba <= '0;
        end else if (cmd == CMD_ACT) begin
            rrd_el      <= TW'(1);
            last_act_ba <= ba;
        end else if (rrd_el != LIM) begin
            rrd_el <= rrd_el + TW'(1);
        end
    end

    // Burst length captured from the mode field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_len <= BLW'(1);
        end else if (cmd == CMD_MODE) begin
            case (addr_mode)
                3'd0:    burst_len <= BLW'(1);
                3'd1:    burst_len <= BLW'(2);
                3'd2:    burst_len <= BLW'(4);
                default: burst_len <= BLW'(8);
            endcase
        end
    end

    // Remaining cycles of a running auto-precharge burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_left <= '0;
            ap_ba   <= '0;
        end else if (ap_start) begin
            ap_left <= burst_len - BLW'(1);
            ap_ba   <= ba;
        end else if (ap_run) begin
            ap_left <= ap_left - BLW'(1);
        end
    end

    // Rule evaluation for the command of this cycle.
    always_comb begin
        hit = '0;
        hit[RULE_MODE_OPEN] = (cmd == CMD_MODE || cmd == CMD_REF) && (|bank_open);
        hit[RULE_MODE_GAP]  = (cmd != CMD_NOP) && (mode_el < TW'(MODE_GAP));
        hit[RULE_RCD]       = is_rw && sel_open && (act_el[ba] < TW'(TRCD));
        hit[RULE_RC]        = (cmd == CMD_ACT) && !sel_open && (act_el[ba] < TW'(TRC));
        hit[RULE_RP]        = (cmd == CMD_ACT) && !sel_open && (pre_el[ba] < TW'(TRP));
        hit[RULE_RRD]       = (cmd == CMD_ACT) && (ba != last_act_ba) && (rrd_el < TW'(TRRD));
        hit[RULE_AP_BUSY]   = is_rw && ap_run;
        hit[RULE_IDLE]      = is_rw && !sel_open;
        hit[RULE_DBL_ACT]   = (cmd == CMD_ACT) && sel_open;
    end

    sdram_err_log #(.NR(NRULE), .CNT_W(CNT_W)) u_log (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .hit    (hit),
        .flags  (err_flags),
        .code   (err_code),
        .counts (err_count)
    );

endmodule

// File: rtl/sdram_proto_mon_chk.sv
// Property checker for the SDRAM protocol monitor, bound to its top.
// Assumes only port-level signals; no internal state is observed.
module sdram_proto_mon_chk
    import sdram_mon_pkg::*;
#(
    parameter int NR    = 9,
    parameter int CNT_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr,
    input logic                cke,
    input logic                cs_n,
    input logic [NR-1:0]       err_flags,
    input logic [CODE_W-1:0]   err_code,
    input logic [NR*CNT_W-1:0] err_count
);

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_flags | $past(err_flags)) == err_flags)); // R12

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_flags == '0 && err_count == '0 && err_code == CODE_NONE)); // R13

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !clr) |=> $stable(err_flags)); // R1

    AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !clr) |=> $stable(err_count)); // R1

    AST_CODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags == '0) |-> (err_code == CODE_NONE)); // R12

    AST_CODE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != CODE_NONE) |-> (int'(err_code) < NR && err_flags[err_code])); // R12

    for (genvar r = 0; r < NR; r++) begin : g_agree
        // Flag and counter of each rule agree.
        always @(negedge clk) begin
            if (rst_n === 1'b1) begin
                AST_FLAG_COUNT_AGREE: assert ((err_count[r*CNT_W +: CNT_W] != '0) == err_flags[r])
                    else $error("flag/count disagree on rule %0d", r); // R13
            end
        end
    end

endmodule

bind sdram_proto_mon sdram_proto_mon_chk #(.NR(NRULE), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .cke       (cke),
    .cs_n      (cs_n),
    .err_flags (err_flags),
    .err_code  (err_code),
    .err_count (err_count)
);

// File: tb/tb_sdram_proto_mon.sv
`timescale 1ns/1ps
module tb_sdram_proto_mon;

    localparam logic [2:0] P_MODE = 3'b000;
    localparam logic [2:0] P_REF  = 3'b001;
    localparam logic [2:0] P_ACT  = 3'b011;
    localparam logic [2:0] P_RD   = 3'b101;
    localparam logic [2:0] P_WR   = 3'b100;
    localparam logic [2:0] P_PRE  = 3'b010;
    localparam logic [2:0] P_NOP  = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic        addr_ap = 1'b0;
    logic [2:0]  addr_mode = '0;
    logic [8:0]  err_flags;
    logic [3:0]  err_code;
    logic [71:0] err_count;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    sdram_proto_mon dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr_ap   (addr_ap),
        .addr_mode (addr_mode),
        .err_flags (err_flags),
        .err_code  (err_code),
        .err_count (err_count)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int count_of(input int r);
        return int'(err_count[r*8 +: 8]);
    endfunction

    // Drives one bus cycle, starting and ending on a falling edge.
    task automatic drive(input logic c_s, input logic c_k, input logic [2:0] p,
                         input logic [1:0] b, input logic ap, input logic [2:0] md);
        cs_n = c_s; cke = c_k; {ras_n, cas_n, we_n} = p;
        ba = b; addr_ap = ap; addr_mode = md;
        @(negedge clk);
        cs_n = 1'b1; cke = 1'b1; {ras_n, cas_n, we_n} = P_NOP;
        addr_ap = 1'b0; addr_mode = '0;
    endtask

    task automatic cmd(input logic [2:0] p, input logic [1:0] b, input logic ap);
        drive(1'b0, 1'b1, p, b, ap, 3'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R14 flags", int'(err_flags), 0);
        check("R14 code", int'(err_code), 15);
        check("R14 counts", int'(err_count == '0), 1);
    endtask

    task automatic t_legal();
        do_reset();
        drive(1'b0, 1'b1, P_MODE, 2'd0, 1'b0, 3'd2);
        idle(1);
        cmd(P_ACT, 2'd0, 1'b0);   // 2 after mode set: legal (R3)
        idle(4);
        cmd(P_RD, 2'd0, 1'b0);    // 5 after activate: legal (R4)
        idle(1);
        cmd(P_WR, 2'd0, 1'b0);
        idle(3);
        cmd(P_PRE, 2'd0, 1'b0);   // 11 after activate
        idle(5);
        cmd(P_ACT, 2'd0, 1'b0);   // 17 after activate, 6 after precharge (R5)
        check("R3/R4/R5 limit exactly met", int'(err_flags), 0);
    endtask

    task automatic t_mode_gap();
        do_reset();
        cmd(P_MODE, 2'd0, 1'b0);
        cmd(P_ACT, 2'd0, 1'b0);
        check("R3 gap flag", int'(err_flags), 1 << 1);
        check("R3 gap code", int'(err_code), 1);
    endtask

    task automatic t_rcd();
        do_reset();
        cmd(P_ACT, 2'd1, 1'b0);
        idle(3);
        cmd(P_RD, 2'd1, 1'b0);
        check("R4 read 4 after activate", int'(err_flags), 1 << 2);
        check("R4 code", int'(err_code), 2);
    endtask

    task automatic t_rc();
        do_reset();
        cmd(P_ACT, 2'd0, 1'b0);
        idle(4);
        cmd(P_PRE, 2'd0, 1'b0);
        idle(4);
        cmd(P_ACT, 2'd0, 1'b0);
        check("R5 reactivate at 10", int'(err_flags), 1 << 3);
    endtask

    task automatic t_rp();
        do_reset();
        cmd(P_ACT, 2'd0, 1'b0);
        idle(19);
        cmd(P_PRE, 2'd0, 1'b0);
        idle(1);
        cmd(P_ACT, 2'd0, 1'b0);
        check("R6 activate 2 after precharge", int'(err_flags), 1 << 4);
    endtask

    task automatic t_rrd();
        do_reset();
        cmd(P_ACT, 2'd0, 1'b0);
        idle(2);
        cmd(P_ACT, 2'd1, 1'b0);
        check("R7 other bank at 3", int'(err_flags), 1 << 5);
        idle(3);
        cmd(P_ACT, 2'd2, 1'b0);
        check("R7 other bank at 4 legal", count_of(5), 1);
    endtask

    task automatic t_mode_open();
        do_reset();
        cmd(P_ACT, 2'd3, 1'b0);
        idle(5);
        cmd(P_REF, 2'd0, 1'b0);
        check("R2 refresh with open bank", int'(err_flags), 1 << 0);
        check("R2 code", int'(err_code), 0);
        idle(2);
        cmd(P_MODE, 2'd0, 1'b0);
        check("R2 count after mode set", count_of(0), 2);
        cmd(P_ACT, 2'd3, 1'b0);
        check("R10/R3 double hit flags", int'(err_flags), (1 << 0) | (1 << 1) | (1 << 8));
        check("R12 lowest code wins", int'(err_code), 1);
    endtask

    task automatic t_idle_access();
        do_reset();
        cmd(P_RD, 2'd2, 1'b0);
        check("R9 read idle bank", int'(err_flags), 1 << 7);
        cmd(P_WR, 2'd2, 1'b1);
        check("R9 write idle bank count", count_of(7), 2);
        check("R9 no burst started", int'(err_flags), 1 << 7);
    endtask

    task automatic t_act_open();
        do_reset();
        cmd(P_ACT, 2'd0, 1'b0);
        idle(19);
        cmd(P_ACT, 2'd0, 1'b0);
        check("R10 activate open bank", int'(err_flags), 1 << 8);
    endtask

    task automatic ap_setup();
        do_reset();
        drive(1'b0, 1'b1, P_MODE, 2'd0, 1'b0, 3'd2);   // burst length 4
        idle(1);
        cmd(P_ACT, 2'd0, 1'b0);   // cycle 2
        idle(3);
        cmd(P_ACT, 2'd1, 1'b0);   // cycle 6
        idle(15);
        cmd(P_RD, 2'd0, 1'b1);    // cycle 22, auto-precharge
    endtask

    task automatic t_auto_pre();
        ap_setup();
        idle(1);
        cmd(P_WR, 2'd1, 1'b0);    // 2 into the burst
        check("R8 access during burst", int'(err_flags), 1 << 6);
        idle(1);
        cmd(P_WR, 2'd1, 1'b0);    // 4 after: burst over
        check("R8 access after burst", count_of(6), 1);
        idle(3);
        cmd(P_ACT, 2'd0, 1'b0);   // 8 after read: closed and precharged
        check("R6/R8 bank reopened cleanly", int'(err_flags), 1 << 6);
        ap_setup();
        idle(6);
        cmd(P_ACT, 2'd0, 1'b0);   // 7 after read: one cycle early
        check("R6 early after auto close", int'(err_flags), 1 << 4);
    endtask

    task automatic t_pre_all();
        do_reset();
        cmd(P_ACT, 2'd0, 1'b0);
        idle(3);
        cmd(P_ACT, 2'd1, 1'b0);
        idle(10);
        cmd(P_PRE, 2'd2, 1'b1);
        cmd(P_REF, 2'd0, 1'b0);
        check("R11 refresh after close-all", int'(err_flags), 0);
        idle(3);
        cmd(P_ACT, 2'd0, 1'b0);
        idle(3);
        cmd(P_ACT, 2'd1, 1'b0);
        check("R11 both banks idle again", int'(err_flags), 0);
    endtask

    task automatic t_ignore();
        do_reset();
        drive(1'b1, 1'b1, P_ACT, 2'd0, 1'b0, 3'd0);
        idle(5);
        cmd(P_RD, 2'd0, 1'b0);
        check("R1 deselected activate ignored", int'(err_flags), 1 << 7);
        do_reset();
        drive(1'b0, 1'b0, P_ACT, 2'd0, 1'b0, 3'd0);
        idle(5);
        cmd(P_RD, 2'd0, 1'b0);
        check("R1 clock-disabled activate ignored", int'(err_flags), 1 << 7);
    endtask

    task automatic t_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R13 clear flags", int'(err_flags), 0);
        check("R13 clear code", int'(err_code), 15);
        check("R13 clear counts", int'(err_count == '0), 1);
        cmd(P_RD, 2'd3, 1'b0);
        check("R13 count restarts", count_of(7), 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_legal();
        t_mode_gap();
        t_rcd();
        t_rc();
        t_rp();
        t_rrd();
        t_mode_open();
        t_idle_access();
        t_act_open();
        t_auto_pre();
        t_pre_all();
        t_ignore();
        t_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule